// File: doc/BRIEF.md
# TLB Process-ID Flush Scanner

This block walks every entry of a pair of translation lookaside buffers, one for instruction fetch and one for data, after it is started with a process identifier. Each buffer has 4 ways of 16 rows, so one walk visits 128 entries. The entries are read through a synchronous read port with one cycle of latency. An entry qualifies when it is valid, is not marked global and its stored process identifier equals the supplied one. For each qualifying entry the block emits a one-cycle flush strobe with the virtual page address rebuilt from the entry's stored virtual page number. Downstream logic uses this ordered stream to drop cached translations of the process.

The block does not invalidate anything itself and does not write the buffers. A controller raises `start_i` for one cycle with the identifier on `pid_i`, then watches `busy_o` and waits for `done_o`.

The controller has four states. `IDLE` waits for a start. `SCAN` issues one read per cycle. `DRAIN` waits one cycle for the data of the last read. `DONE` pulses the done flag. The transitions are: IDLE to SCAN on `start_i`; SCAN to SCAN while entries remain; SCAN to DRAIN after the last entry is issued; DRAIN to DONE unconditionally; DONE to IDLE unconditionally. A synchronous reset forces IDLE from any state.

Top module: `tlb_pid_flush_scan`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o`, `done_o`, `flush_o` and `rd_en_o` are 0 and `flush_addr_o` is 0.
- R2: A `start_i` seen in IDLE at a clock edge makes `busy_o` and `rd_en_o` high in the next cycle (cycle 0). In cycle e, for e = 0..127, the read address is entry e, where e = {`rd_tlb_o`, `rd_way_o`, `rd_idx_o`}. The buffer select is the outermost loop, the way is the middle loop and the row is the inner loop. `rd_en_o` is high in cycles 0..127 only.
- R3: Entry e qualifies when its data bit 3 (valid) is 1, its data bit 4 (global) is 0, and its tag bits [7:0] equal `pid_i[7:0]` as captured at start. Bits [31:8] of `pid_i` and all other data bits have no effect.
- R4: For each qualifying entry e, `flush_o` is high in cycle e+2 and `flush_addr_o` equals tag bits [31:13] followed by 13 zero bits. Tag bits [12:8] have no effect. Back-to-back qualifying entries give back-to-back strobes.
- R5: `busy_o` is high in cycles 0..128. `done_o` is high in cycle 129 only, with `busy_o` low. The block is back in IDLE in cycle 130.
- R6: A `start_i` in any state other than IDLE is ignored. The walk order, the captured identifier and the end of the walk do not change, and a start in the DONE cycle does not begin a new walk.
- R7: Asserting `rst` in the middle of a walk returns the block to IDLE. In the cycle after reset falls the outputs are as in R1, and the next start begins a fresh walk from entry 0.
- R8: `flush_addr_o` is 0 in every cycle in which `flush_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a walk (used only in IDLE) |
| pid_i | input | 32 | Process identifier; only bits [7:0] are used |
| rd_en_o | output | 1 | Read request to the entry storage |
| rd_tlb_o | output | 1 | Buffer select of the read (0 instruction, 1 data) |
| rd_way_o | output | 2 | Way of the read |
| rd_idx_o | output | 4 | Row of the read |
| rd_tag_i | input | 32 | Tag word of the read, valid the cycle after `rd_en_o` |
| rd_data_i | input | 32 | Data word of the read, valid the cycle after `rd_en_o` |
| flush_o | output | 1 | One strobe per qualifying entry |
| flush_addr_o | output | 32 | Virtual page address to flush |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting from the start edge, the read address of entry e is due in cycle e. Its data returns in cycle e+1, and the registered flush result is due in cycle e+2. Busy must hold through cycle 128, and done is due in cycle 129 alone. The bench samples each of these at the falling edge of the exact cycle in which it is due. It compares them against entry contents that it generates itself from R3 and R4, so each read slot, strobe slot and completion slot is checked in its own cycle and not only by a total count. The reset and start-while-busy cases are sampled one cycle after the stimulus, in the cycle in which the registered state first shows the effect.

// File: rtl/tlbfs_pkg.sv
package tlbfs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } scan_state_t;

    // Field positions of the stored entry words
    localparam int DATA_VALID_BIT  = 3;
    localparam int DATA_GLOBAL_BIT = 4;
    localparam int TAG_PID_LSB     = 0;

endpackage

// File: rtl/tlbfs_walk_ctr.sv
module tlbfs_walk_ctr #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // The entry total is a power of two, so the final entry is all ones.
    assign last = (count == {CNT_W{1'b1}});

endmodule

// File: rtl/tlbfs_entry_qual.sv
module tlbfs_entry_qual
    import tlbfs_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PID_W      = 8,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [WORD_W-1:0] tag,
    input  logic [WORD_W-1:0] data,
    input  logic [PID_W-1:0]  pid,
    output logic              hit,
    output logic [WORD_W-1:0] vaddr
);

    logic pid_eq;

    assign pid_eq = (tag[TAG_PID_LSB +: PID_W] == pid);
    assign hit    = data[DATA_VALID_BIT] && !data[DATA_GLOBAL_BIT] && pid_eq;
    assign vaddr  = {tag[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

endmodule

// File: rtl/tlb_pid_flush_scan.sv
module tlb_pid_flush_scan
    import tlbfs_pkg::*;
#(
    parameter int NUM_TLBS   = 2,
    parameter int NUM_WAYS   = 4,
    parameter int NUM_SETS   = 16,
    parameter int WORD_W     = 32,
    parameter int PID_W      = 8,
    parameter int PAGE_SHIFT = 13,
    localparam int TLB_W = (NUM_TLBS > 1) ? $clog2(NUM_TLBS) : 1,
    localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] pid_i,
    output logic              rd_en_o,
    output logic [TLB_W-1:0]  rd_tlb_o,
    output logic [WAY_W-1:0]  rd_way_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [WORD_W-1:0] rd_tag_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              flush_o,
    output logic [WORD_W-1:0] flush_addr_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int CNT_W = TLB_W + WAY_W + IDX_W;

    scan_state_t       state_q, state_d;
    logic [CNT_W-1:0]  entry_cnt;
    logic              entry_last;
    logic              cnt_clear, cnt_step;
    logic [PID_W-1:0]  pid_q;
    logic              rd_vld_q;
    logic              ent_hit;
    logic [WORD_W-1:0] ent_vaddr;
    logic              flush_q;
    logic [WORD_W-1:0] flush_addr_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SCAN;
            ST_SCAN:  if (entry_last) state_d = ST_DRAIN;
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        rd_en_o   = 1'b0;
        busy_o    = 1'b0;
        done_o    = 1'b0;
        cnt_clear = 1'b0;
        cnt_step  = 1'b0;
        unique case (state_q)
            ST_IDLE:  cnt_clear = 1'b1;
            ST_SCAN:  begin
                rd_en_o  = 1'b1;
                busy_o   = 1'b1;
                cnt_step = 1'b1;
            end
            ST_DRAIN: busy_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  cnt_clear = 1'b1;
        endcase
    end

    // Identifier captured only when a walk is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            pid_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            pid_q <= pid_i[PID_W-1:0];
        end
    end

    tlbfs_walk_ctr #(
        .CNT_W (CNT_W)
    ) u_walk_ctr (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .step  (cnt_step),
        .count (entry_cnt),
        .last  (entry_last)
    );

    // Buffer select outermost, way in the middle, row innermost
    assign rd_tlb_o = entry_cnt[CNT_W-1 -: TLB_W];
    assign rd_way_o = entry_cnt[IDX_W +: WAY_W];
    assign rd_idx_o = entry_cnt[0 +: IDX_W];

    tlbfs_entry_qual #(
        .WORD_W     (WORD_W),
        .PID_W      (PID_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_entry_qual (
        .tag   (rd_tag_i),
        .data  (rd_data_i),
        .pid   (pid_q),
        .hit   (ent_hit),
        .vaddr (ent_vaddr)
    );

    // Read-data valid tracking and registered flush result
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld_q     <= 1'b0;
            flush_q      <= 1'b0;
            flush_addr_q <= '0;
        end else begin
            rd_vld_q     <= rd_en_o;
            flush_q      <= rd_vld_q && ent_hit;
            flush_addr_q <= (rd_vld_q && ent_hit) ? ent_vaddr : '0;
        end
    end

    assign flush_o      = flush_q;
    assign flush_addr_o = flush_addr_q;

endmodule

// File: rtl/tlbfs_checker.sv
module tlbfs_checker #(
    parameter int TLB_W      = 1,
    parameter int WAY_W      = 2,
    parameter int IDX_W      = 4,
    parameter int WORD_W     = 32,
    parameter int PAGE_SHIFT = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              busy_o,
    input logic              done_o,
    input logic              flush_o,
    input logic [WORD_W-1:0] flush_addr_o,
    input logic              rd_en_o,
    input logic [TLB_W-1:0]  rd_tlb_o,
    input logic [WAY_W-1:0]  rd_way_o,
    input logic [IDX_W-1:0]  rd_idx_o
);

    logic [TLB_W+WAY_W+IDX_W-1:0] rd_entry;
    assign rd_entry = {rd_tlb_o, rd_way_o, rd_idx_o};

    // R2
    reads_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |-> busy_o);

    // R2
    walk_starts_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en_o) |-> (rd_entry == '0));

    // R6
    walk_not_restarted_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_o && $past(rd_en_o)) |-> (rd_entry == $past(rd_entry) + 1'b1));

    // R4
    flush_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(rd_en_o, 2));

    // R4
    flush_page_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> (flush_addr_o[PAGE_SHIFT-1:0] == '0));

    // R5
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

    // R8
    idle_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !flush_o |-> (flush_addr_o == '0));

endmodule

bind tlb_pid_flush_scan tlbfs_checker #(
    .TLB_W      (TLB_W),
    .WAY_W      (WAY_W),
    .IDX_W      (IDX_W),
    .WORD_W     (WORD_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_tlbfs_checker (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .flush_o      (flush_o),
    .flush_addr_o (flush_addr_o),
    .rd_en_o      (rd_en_o),
    .rd_tlb_o     (rd_tlb_o),
    .rd_way_o     (rd_way_o),
    .rd_idx_o     (rd_idx_o)
);

// File: tb/tlb_pid_flush_scan_bench.sv
module tlb_pid_flush_scan_bench;

    localparam int N_ENT = 128;

    typedef struct packed {
        logic [31:0] pid;
        logic [7:0]  seed;
        logic [1:0]  mode;    // 0 mixed, 1 all global, 2 all qualifying
        logic        inject;  // pulse start mid-walk and in the done cycle
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{pid: 32'h0000_0011, seed: 8'd3, mode: 2'd0, inject: 1'b0},
        '{pid: 32'hABCD_EF12, seed: 8'd7, mode: 2'd0, inject: 1'b1},
        '{pid: 32'h0000_0013, seed: 8'd1, mode: 2'd0, inject: 1'b0},
        '{pid: 32'h0000_0012, seed: 8'd0, mode: 2'd1, inject: 1'b0},
        '{pid: 32'hFFFF_FF12, seed: 8'd5, mode: 2'd2, inject: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] pid_i = '0;
    logic        rd_en_o;
    logic [0:0]  rd_tlb_o;
    logic [1:0]  rd_way_o;
    logic [3:0]  rd_idx_o;
    logic [31:0] rd_tag_i, rd_data_i;
    logic        flush_o;
    logic [31:0] flush_addr_o;
    logic        busy_o, done_o;

    logic [31:0] mem_tag  [N_ENT];
    logic [31:0] mem_data [N_ENT];

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    tlb_pid_flush_scan u_tlb_pid_flush_scan (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .pid_i        (pid_i),
        .rd_en_o      (rd_en_o),
        .rd_tlb_o     (rd_tlb_o),
        .rd_way_o     (rd_way_o),
        .rd_idx_o     (rd_idx_o),
        .rd_tag_i     (rd_tag_i),
        .rd_data_i    (rd_data_i),
        .flush_o      (flush_o),
        .flush_addr_o (flush_addr_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    // Synchronous entry storage model
    always @(posedge clk) begin
        if (rd_en_o) begin
            rd_tag_i  <= mem_tag[{rd_tlb_o, rd_way_o, rd_idx_o}];
            rd_data_i <= mem_data[{rd_tlb_o, rd_way_o, rd_idx_o}];
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [31:0] pid, input int seed, input int mode);
        for (int e = 0; e < N_ENT; e++) begin
            logic [18:0] vpn;
            logic [7:0]  pf;
            logic        v, g;
            vpn = 19'((e * 613 + seed * 97) & 32'h7FFFF);
            pf  = 8'h10 + 8'((e ^ seed) & 3);
            v   = ((e + seed) % 3) != 0;
            g   = (e % 5) == (seed % 5);
            if (mode == 1) begin
                pf = pid[7:0]; v = 1'b1; g = 1'b1;
            end else if (mode == 2) begin
                pf = pid[7:0]; v = 1'b1; g = 1'b0;
            end
            // tag bits [12:8] and data bits outside 3 and 4 carry junk
            mem_tag[e]  = {vpn, 5'h1A, pf};
            mem_data[e] = {27'(e * 7 + seed + 32'h155), g, v, 3'b101};
        end
    endtask

    function automatic logic qual(input int e, input logic [31:0] pid);
        return mem_data[e][3] && !mem_data[e][4] && (mem_tag[e][7:0] == pid[7:0]);
    endfunction

    task automatic run_walk(input vec_t v);
        int exp_cnt = 0;
        int got_cnt = 0;
        fill(v.pid, int'(v.seed), int'(v.mode));
        @(negedge clk);
        start_i = 1'b1;
        pid_i   = v.pid;
        @(negedge clk);
        start_i = 1'b0;
        pid_i   = 32'h0000_00EE;
        for (int c = 0; c < 131; c++) begin
            // R2 read slot and order
            check("R2 rd_en", {31'b0, rd_en_o}, {31'b0, (c < N_ENT)});
            if (c < N_ENT)
                check("R2 rd_addr", {25'b0, rd_tlb_o, rd_way_o, rd_idx_o}, 32'(c));
            // R5 busy and done slots
            check("R5 busy", {31'b0, busy_o}, {31'b0, (c <= 128)});
            check("R5 done", {31'b0, done_o}, {31'b0, (c == 129)});
            // R3 R4 R8 flush stream
            if (c >= 2 && c - 2 < N_ENT && qual(c - 2, v.pid)) begin
                exp_cnt++;
                check("R4 flush", {31'b0, flush_o}, 32'd1);
                check("R4 flush_addr", flush_addr_o,
                      {mem_tag[c - 2][31:13], 13'b0});
            end else begin
                check("R3 no_flush", {31'b0, flush_o}, 32'd0);
                check("R8 addr_zero", flush_addr_o, 32'd0);
            end
            if (flush_o) got_cnt++;
            // R6 starts while not idle are ignored
            if (v.inject) begin
                start_i = (c == 50) || (c == 129);
                pid_i   = 32'h0000_0010;
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        check("R6 idle_after_done", {30'b0, busy_o, rd_en_o}, 32'd0);
        check("R3 flush_total", 32'(got_cnt), 32'(exp_cnt));
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy", {31'b0, busy_o}, 32'd0);
        check("R1 rd_en", {31'b0, rd_en_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outs", {28'b0, busy_o, done_o, flush_o, rd_en_o}, 32'd0);
        check("R1 addr", flush_addr_o, 32'd0);

        for (int i = 0; i < 5; i++) begin
            run_walk(VECS[i]);
        end

        // R7 reset in the middle of a walk
        fill(32'h11, 3, 2);
        @(negedge clk);
        start_i = 1'b1;
        pid_i   = 32'h11;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check("R7 mid_busy", {31'b0, busy_o}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R7 outs", {28'b0, busy_o, done_o, flush_o, rd_en_o}, 32'd0);
        check("R7 addr", flush_addr_o, 32'd0);

        // R7 fresh walk after the reset
        run_walk(VECS[0]);

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule